// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a recovery watchdog for a small microcontroller core. It leaves every reset disarmed. Software arms it, and later keeps it from expiring, by writing a two-byte key to one write-only address on a simple peripheral write bus. Once armed, a 13-bit counter steps on each machine-cycle enable. When the counter has reached its all-ones value, the block drives an active-high reset pulse of fixed length on its output and returns to the disarmed state.

The count can be gated by the core's low-power status. In idle, a control bit decides whether counting goes on or freezes. In power-down the count always stops. If power-down is left through a level-sensitive, active-low wake interrupt, counting stays stopped until that line goes high again. There is no read path: neither the counter nor the key register can be observed from the bus.

Top module: `keyed_wdt`

## Requirements
- R1: After hardware reset the watchdog is disarmed, `wdt_rst_o` is low, and no reset pulse is produced however long the machine-cycle enable runs.
- R2: A bus write of 0x1E to address 0xA6, followed by a write of 0xE1 to address 0xA6, arms the watchdog and clears the count to zero. Writes to other addresses may sit between the two key writes. With the enable high on every cycle, the pulse rises after the 8192nd clock edge that follows the edge taking the 0xE1 write.
- R3: While armed, the count advances by one on each clock edge where `mc_en_i` is high and no gating applies. Every edge with `mc_en_i` low delays the pulse by one edge.
- R4: Once the count holds 0x1FFF, the pulse starts on the next clock edge.
- R5: The reset pulse stays high for exactly 96 clock cycles.
- R6: Once armed, no bus write other than a full key sequence changes when the pulse occurs. Only a hardware reset or the overflow pulse disarms the watchdog.
- R7: If a write to 0xA6 directly follows 0x1E and carries any value other than 0xE1, the sequence is aborted, and a new 0x1E is then needed. Writes to other addresses never advance the sequence or abort it.
- R8: In idle with `stop_in_idle_i` = 0, counting continues unchanged. In idle with `stop_in_idle_i` = 1, the count freezes and resumes when idle ends.
- R9: While `pdown_i` is high the count stops. When `pdown_i` falls while `wake_int_n_i` is low, the count stays stopped until `wake_int_n_i` is high.
- R10: The overflow pulse clears both the armed state and the key-sequence state. Writes made while the pulse is high are ignored, so an 0xE1 after the pulse does not arm.
- R11: A key sequence that completes before overflow restarts the full 8192-edge interval from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | 8 | Bus write address |
| wr_data_i | input | 8 | Bus write data |
| idle_i | input | 1 | Core is in idle |
| stop_in_idle_i | input | 1 | 1 = freeze count while idle |
| pdown_i | input | 1 | Core is in power-down |
| wake_int_n_i | input | 1 | Level wake interrupt, active low |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions take all inputs to be synchronous to `clk`, and each bus write to be a single strobe cycle. They do not assume anything about how the idle, power-down and wake inputs relate to one another. The stimulus changes every input only at the falling clock edge, and it holds each gating condition for a whole number of rising edges, so the bench can predict pulse times by adding the stalled edges to 8192. The wake line is pulled low only inside power-down or directly after it, as a real interrupt-driven wake would do.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        KEY_WAIT_FIRST  = 1'b0,
        KEY_WAIT_SECOND = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              svc_o
);
    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t r_d, r_q;
    logic      hit;

    always_comb begin
        hit   = wr_en_i && (wr_addr_i == KEY_ADDR);
        r_d   = r_q;
        svc_o = 1'b0;
        if (clear_i) begin
            r_d.st = KEY_WAIT_FIRST;
        end else if (hit) begin
            unique case (r_q.st)
                KEY_WAIT_FIRST: begin
                    if (wr_data_i == KEY_FIRST) r_d.st = KEY_WAIT_SECOND;
                end
                KEY_WAIT_SECOND: begin
                    // any value other than the second key aborts
                    svc_o  = (wr_data_i == KEY_SECOND);
                    r_d.st = KEY_WAIT_FIRST;
                end
                default: r_d.st = KEY_WAIT_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: KEY_WAIT_FIRST};
        else        r_q <= r_d;
    end

    // R7: a wrong value after the first key returns to waiting for the first key
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == KEY_WAIT_SECOND && wr_en_i && wr_addr_i == KEY_ADDR
         && wr_data_i != KEY_SECOND)
        |=> r_q.st == KEY_WAIT_FIRST);

    // R10: clearing discards a partial sequence
    p_clear_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> r_q.st == KEY_WAIT_FIRST);

    // R7: writes elsewhere leave the sequence state alone
    p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && wr_en_i && wr_addr_i != KEY_ADDR) |=> $stable(r_q.st));
endmodule

// File: rtl/wdt_gate.sv
module wdt_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic mc_en_i,
    input  logic idle_i,
    input  logic stop_in_idle_i,
    input  logic pdown_i,
    input  logic wake_int_n_i,
    output logic cnt_en_o
);
    typedef struct packed {
        logic hold;
    } gate_regs_t;

    gate_regs_t r_d, r_q;
    logic       pd_block;

    always_comb begin
        // power-down blocks; after it, the block stays until the wake line is high
        pd_block   = pdown_i || (r_q.hold && !wake_int_n_i);
        r_d.hold   = pd_block;
        cnt_en_o   = armed_i && mc_en_i && !pd_block
                     && !(idle_i && stop_in_idle_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{hold: 1'b0};
        else        r_q <= r_d;
    end

    // R9: after power-down, a low wake line keeps the count stopped
    p_pd_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_i ##1 !wake_int_n_i |-> !cnt_en_o);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_regs_t;

    pulse_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i && r_q.left == '0)  r_d.left = PW'(PULSE_LEN);
        else if (r_q.left != '0)        r_d.left = r_q.left - 1'b1;
        busy_o = (r_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{left: '0};
        else        r_q <= r_d;
    end

    // R5: a start raises the pulse on the next edge
    p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R5: the pulse cannot end before its count has run out
    p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.left > PW'(1)) |=> busy_o);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int CNT_W     = 13,
    parameter int PULSE_LEN = 96,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              idle_i,
    input  logic              stop_in_idle_i,
    input  logic              pdown_i,
    input  logic              wake_int_n_i,
    output logic              wdt_rst_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } wdt_regs_t;

    wdt_regs_t r_d, r_q;
    logic      svc, cnt_en, fire, pulse_busy, key_clear;

    assign fire      = r_q.armed && (r_q.count == CNT_MAX);
    assign key_clear = fire || pulse_busy;

    wdt_key_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) i_key (
        .clk(clk), .rst_n(rst_n), .clear_i(key_clear),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .svc_o(svc)
    );

    wdt_gate i_gate (
        .clk(clk), .rst_n(rst_n), .armed_i(r_q.armed), .mc_en_i(mc_en_i),
        .idle_i(idle_i), .stop_in_idle_i(stop_in_idle_i), .pdown_i(pdown_i),
        .wake_int_n_i(wake_int_n_i), .cnt_en_o(cnt_en)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
        .clk(clk), .rst_n(rst_n), .start_i(fire), .busy_o(pulse_busy)
    );

    always_comb begin
        r_d = r_q;
        if (fire) begin
            r_d.armed = 1'b0;
            r_d.count = '0;
        end else if (svc) begin
            r_d.armed = 1'b1;
            r_d.count = '0;
        end else if (cnt_en && r_q.count != CNT_MAX) begin
            r_d.count = r_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{armed: 1'b0, count: '0};
        else        r_q <= r_d;
    end

    assign wdt_rst_o = pulse_busy;

    // R4: a full count raises the reset pulse on the next edge
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.armed && r_q.count == CNT_MAX) |=> wdt_rst_o);

    // R6: only the overflow disarms an armed watchdog
    p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.armed && !(r_q.count == CNT_MAX)) |=> r_q.armed);

    // R3: a gated cycle leaves the count unchanged
    p_count_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !svc && !fire) |=> $stable(r_q.count));

    // R3: an enabled cycle advances the count by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !svc && !fire && r_q.count != CNT_MAX)
        |=> r_q.count == CNT_W'($past(r_q.count) + 1'b1));

    // R8: idle with the freeze bit holds the count
    p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && stop_in_idle_i && !svc && !fire) |=> $stable(r_q.count));

    // R2: a completed key sequence arms and zeroes the count
    p_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !fire) |=> (r_q.armed && r_q.count == '0));

    // R10: while the pulse is high the watchdog is disarmed and ignores the key
    p_pulse_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_busy |-> (!r_q.armed && !svc));
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int FULL     = 8192;
    localparam int PLEN     = 96;
    localparam int NOWAIT   = 8400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       idle = 1'b0, stop_idle = 1'b0, pdown = 1'b0, wake_n = 1'b1;
    logic       wdt_rst;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    int mark = 0;

    always #5 clk = ~clk;
    always @(posedge clk) edge_cnt = edge_cnt + 1;

    keyed_wdt i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .mc_en_i(mc_en), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .idle_i(idle),
        .stop_in_idle_i(stop_idle), .pdown_i(pdown), .wake_int_n_i(wake_n),
        .wdt_rst_o(wdt_rst)
    );

    // each vector: three writes {addr,data} and whether the watchdog ends armed
    localparam logic [48:0] VEC [0:5] = '{
        {8'hA6, 8'h00, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b1},
        {8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b0},
        {8'hA6, 8'h1E, 8'hA5, 8'h55, 8'hA6, 8'hE1, 1'b1},
        {8'hA6, 8'hE1, 8'hA6, 8'h1E, 8'hA6, 8'h00, 1'b0},
        {8'hA6, 8'h1E, 8'hA6, 8'hE0, 8'hA6, 8'hE1, 1'b0},
        {8'hA7, 8'h1E, 8'hA6, 8'h00, 8'hA6, 8'hE1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle = 0; stop_idle = 0; pdown = 0; wake_n = 1; wr_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mark = edge_cnt;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mark = edge_cnt;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    // edges from mark until the pulse is seen, or -1
    task automatic wait_pulse(input int limit, output int n);
        while (!wdt_rst && (edge_cnt - mark) < limit) @(negedge clk);
        n = wdt_rst ? (edge_cnt - mark) : -1;
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (wdt_rst && w < 1000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic idle_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n, w, arm_mark;
        mc_en = 1'b1;
        do_reset();
        // R1: reset state
        check("R1 reset output", int'(wdt_rst), 0);

        // R2 R7 R1: key-sequence vector table
        foreach (VEC[i]) begin
            do_reset();
            wr(VEC[i][48:41], VEC[i][40:33]);
            wr(VEC[i][32:25], VEC[i][24:17]);
            wr(VEC[i][16:9],  VEC[i][8:1]);
            wait_pulse(NOWAIT, n);
            check(VEC[i][0] ? "R2 arm timing" : "R7 R1 no arm", n,
                  VEC[i][0] ? FULL : -1);
        end

        // R4 R5 R10: overflow pulse width, then key ignored during pulse
        do_reset();
        arm();
        wait_pulse(NOWAIT, n);
        check("R4 overflow edge", n, FULL);
        wr(8'hA6, 8'h1E);
        pulse_width(w);
        check("R5 pulse width", w + 2, PLEN);
        wr(8'hA6, 8'hE1);
        wait_pulse(NOWAIT, n);
        check("R10 disarmed after pulse", n, -1);

        // R6: stray writes do not move or stop the overflow
        do_reset();
        arm();
        arm_mark = mark;
        wr(8'hA6, 8'h00);
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h00);
        mark = arm_mark;
        wait_pulse(NOWAIT, n);
        check("R6 sticky arm", n, FULL);

        // R11: service mid-interval restarts it
        do_reset();
        arm();
        idle_edges(5000);
        arm();
        wait_pulse(NOWAIT, n);
        check("R11 service restart", n, FULL);

        // R3: machine-cycle enable low for 100 edges
        do_reset();
        arm();
        idle_edges(500);
        mc_en = 1'b0;
        idle_edges(100);
        mc_en = 1'b1;
        wait_pulse(NOWAIT + 200, n);
        check("R3 enable stall", n, FULL + 100);

        // R8: idle without freeze keeps counting
        do_reset();
        arm();
        idle = 1'b1;
        wait_pulse(NOWAIT, n);
        idle = 1'b0;
        check("R8 idle counts", n, FULL);

        // R8: idle with freeze bit for 300 edges
        do_reset();
        stop_idle = 1'b1;
        arm();
        idle_edges(200);
        idle = 1'b1;
        idle_edges(300);
        idle = 1'b0;
        wait_pulse(NOWAIT + 400, n);
        check("R8 idle freeze", n, FULL + 300);

        // R9: power-down 200 edges, then wake line low 150 edges
        do_reset();
        arm();
        idle_edges(300);
        pdown = 1'b1; wake_n = 1'b0;
        idle_edges(200);
        pdown = 1'b0;
        idle_edges(150);
        wake_n = 1'b1;
        wait_pulse(NOWAIT + 400, n);
        check("R9 power-down wake", n, FULL + 350);

        // R1: hardware reset during a pulse ends it
        do_reset();
        arm();
        wait_pulse(NOWAIT, n);
        idle_edges(10);
        do_reset();
        check("R1 reset clears pulse", int'(wdt_rst), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule